// File: doc/BRIEF.md
# Tri-Level Pulse Up/Down Counter

This block holds an 8-bit setting that is adjusted through one control line with three resting levels. Two comparators outside the block reduce the line to a "below low threshold" bit and an "above high threshold" bit. When both bits are clear the line sits at its middle rest level. A swing from the middle to the low side and back raises the setting by one. A swing to the high side and back lowers it by one. The step is taken only when the line returns to the middle. The length of each swing is measured in clock ticks, and only swings long enough to qualify take effect.

Adjustment is allowed only while the enable input is high. After enable rises there is a start delay. After the delay, the first qualified swing is thrown away, because the line state is not trusted at that point. A store controller outside the block can ask for the next qualified swing to be thrown away in the same way. A load strobe writes a restored value straight into the setting, and the load wins over any step in the same cycle. The setting saturates at both ends and never wraps.

Top module: `tri_level_counter`

## Requirements
- R1: A qualified swing to the low side (`line_lo_i`=1, `line_hi_i`=0) adds one to `count_o`.
- R2: A qualified swing to the high side (`line_hi_i`=1, `line_lo_i`=0) subtracts one from `count_o`. When both comparator bits are set, or both are clear, the line is read as the middle level.
- R3: The step happens only after the line returns to the middle. While the swing is still held, `count_o` does not change, however long the swing lasts.
- R4: `count_o` stops at 0 and at 2^CNT_W-1. It never wraps.
- R5: A swing lasting at least ACCEPT_TICKS cycles qualifies. Shorter swings have no effect. This includes swings between REJECT_TICKS and ACCEPT_TICKS.
- R6: A qualified swing that completes fewer than GAP_TICKS cycles after the previous applied step has no effect.
- R7: While `en_i` is low, `count_o` holds its value and swings have no effect.
- R8: After `en_i` rises, swings that complete within START_TICKS cycles are dropped. The first qualified swing after that delay is also discarded.
- R9: A one-cycle pulse on `ignore_next_i` causes the next qualified swing to be discarded. The swing after it counts normally.
- R10: A swing that crosses from one side directly to the other, without passing through the middle, is discarded when the line returns to the middle.
- R11: `load_i` copies `load_val_i` into `count_o` on the next cycle. A load takes priority over a step in the same cycle.
- R12: Reset sets `count_o` to RESET_VAL (default 128). After reset the block discards the first qualified swing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Adjustment enable |
| line_lo_i | input | 1 | Control line is below the low threshold (asynchronous) |
| line_hi_i | input | 1 | Control line is above the high threshold (asynchronous) |
| ignore_next_i | input | 1 | Request to discard the next qualified swing |
| load_i | input | 1 | Load strobe |
| load_val_i | input | CNT_W | Value to load |
| count_o | output | CNT_W | Current setting |

## Verification
Every internal state in this block shows up at `count_o` within a few cycles of a swing ending. A stale discard flag, a start timer that never expires, or a spacing counter that does not clear each shows up as a missing or an extra step of exactly one. The error appears about five clocks after the line returns to the middle. A wrong width comparison moves the threshold by one tick, so the bench sweeps swing widths on both sides of the accept limit. Saturation faults show as a wrap to the opposite end on the first swing past the limit.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } level_t;

    typedef enum logic [1:0] {
        W_GLITCH   = 2'd0,
        W_MARGINAL = 2'd1,
        W_VALID    = 2'd2
    } width_class_t;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_LOW   = 2'd1,
        Q_HIGH  = 2'd2,
        Q_SPOIL = 2'd3
    } qual_state_t;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    // Both comparators firing is physically contradictory; read it as rest.
    function automatic level_t decode_level(input logic lo, input logic hi);
        if (lo && !hi)      return LVL_LOW;
        else if (hi && !lo) return LVL_HIGH;
        else                return LVL_MID;
    endfunction

    function automatic width_class_t classify(input int unsigned width,
                                              input int unsigned reject_lim,
                                              input int unsigned accept_lim);
        if (width >= accept_lim)      return W_VALID;
        else if (width >= reject_lim) return W_MARGINAL;
        else                          return W_GLITCH;
    endfunction

endpackage

// File: rtl/tlc_level_sync.sv
module tlc_level_sync
    import tlc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   lo_i,
    input  logic   hi_i,
    output level_t lvl_o
);
    logic [STAGES-1:0] lo_sh;
    logic [STAGES-1:0] hi_sh;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_sh[s] <= 1'b0;
                    hi_sh[s] <= 1'b0;
                end else if (s == 0) begin
                    lo_sh[s] <= lo_i;
                    hi_sh[s] <= hi_i;
                end else begin
                    lo_sh[s] <= lo_sh[(s == 0) ? 0 : s-1];
                    hi_sh[s] <= hi_sh[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign lvl_o = decode_level(lo_sh[STAGES-1], hi_sh[STAGES-1]);
endmodule

// File: rtl/tlc_pulse_qual.sv
module tlc_pulse_qual
    import tlc_pkg::*;
#(
    parameter int REJECT_TICKS = 20,
    parameter int ACCEPT_TICKS = 200
) (
    input  logic   clk,
    input  logic   rst,
    input  level_t lvl_i,
    output step_t  qual_o
);
    localparam int WW = $clog2(ACCEPT_TICKS + 2);
    localparam logic [WW-1:0] W_SAT = WW'(ACCEPT_TICKS);

    qual_state_t     state_q;
    logic [WW-1:0]   width_q;
    step_t           qual_q;
    logic            valid_w;

    assign valid_w = (classify(int'(width_q), REJECT_TICKS, ACCEPT_TICKS) == W_VALID);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= Q_IDLE;
            width_q <= '0;
            qual_q  <= '0;
        end else begin
            qual_q <= '0;
            case (state_q)
                Q_IDLE: begin
                    if (lvl_i == LVL_LOW) begin
                        state_q <= Q_LOW;
                        width_q <= WW'(1);
                    end else if (lvl_i == LVL_HIGH) begin
                        state_q <= Q_HIGH;
                        width_q <= WW'(1);
                    end
                end
                Q_LOW: begin
                    if (lvl_i == LVL_LOW) begin
                        if (width_q != W_SAT) width_q <= width_q + 1'b1;
                    end else if (lvl_i == LVL_HIGH) begin
                        state_q <= Q_SPOIL;
                    end else begin
                        state_q   <= Q_IDLE;
                        qual_q.up <= valid_w;
                    end
                end
                Q_HIGH: begin
                    if (lvl_i == LVL_HIGH) begin
                        if (width_q != W_SAT) width_q <= width_q + 1'b1;
                    end else if (lvl_i == LVL_LOW) begin
                        state_q <= Q_SPOIL;
                    end else begin
                        state_q   <= Q_IDLE;
                        qual_q.dn <= valid_w;
                    end
                end
                default: begin
                    if (lvl_i == LVL_MID) state_q <= Q_IDLE;
                end
            endcase
        end
    end

    assign qual_o = qual_q;

    // R3: a qualified swing is reported only after the line is back at rest
    a_r3_trailing_edge: assert property (@(posedge clk) disable iff (rst)
        (qual_q.up || qual_q.dn) |-> $past(lvl_i) == LVL_MID);

    // R5: a reported swing had reached the accept width
    a_r5_width_met: assert property (@(posedge clk) disable iff (rst)
        (qual_q.up || qual_q.dn) |-> $past(width_q) >= W_SAT);

    // R10: a spoiled swing never yields a report when it ends
    a_r10_spoil_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == Q_SPOIL) |=> !(qual_q.up || qual_q.dn));
endmodule

// File: rtl/tlc_step_gate.sv
module tlc_step_gate
    import tlc_pkg::*;
#(
    parameter int GAP_TICKS   = 10,
    parameter int START_TICKS = 50
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  logic  ignore_i,
    input  step_t qual_i,
    output step_t step_o
);
    localparam int SW = $clog2(START_TICKS + 2);
    localparam int GW = $clog2(GAP_TICKS + 2);
    localparam logic [SW-1:0] START_END = SW'(START_TICKS);
    localparam logic [GW-1:0] GAP_LOAD  = GW'(GAP_TICKS);

    logic [SW-1:0] start_q;
    logic [GW-1:0] gap_q;
    logic          skip_q;
    step_t         step_q;
    logic          ready_w;
    logic          take_w;

    assign ready_w = en_i && (start_q == START_END);
    assign take_w  = ready_w && (gap_q == '0) && (qual_i.up || qual_i.dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            gap_q   <= '0;
            skip_q  <= 1'b1;
            step_q  <= '0;
        end else begin
            step_q <= '0;
            if (!en_i)                  start_q <= '0;
            else if (start_q != START_END) start_q <= start_q + 1'b1;

            if (gap_q != '0) gap_q <= gap_q - 1'b1;

            if (take_w) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else begin
                    step_q <= qual_i;
                    gap_q  <= GAP_LOAD;
                end
            end

            if (!en_i || ignore_i) skip_q <= 1'b1;
        end
    end

    assign step_o = step_q;

    // R7: no step is issued in the cycle after enable was low
    a_r7_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !(step_q.up || step_q.dn));

    // R6: two steps are never issued back to back
    a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
        (step_q.up || step_q.dn) |=> !(step_q.up || step_q.dn));

    // R1/R2: a step has exactly one direction
    a_r1_one_direction: assert property (@(posedge clk) disable iff (rst)
        !(step_q.up && step_q.dn));

    // R9: a discard request means the next cycle cannot step
    a_r9_ignore_blocks: assert property (@(posedge clk) disable iff (rst)
        ignore_i |=> skip_q);
endmodule

// File: rtl/tlc_sat_counter.sv
module tlc_sat_counter
    import tlc_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int RESET_VAL = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RST = CNT_W'(RESET_VAL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                             cnt_q <= RST;
        else if (load_i)                     cnt_q <= load_val_i;
        else if (step_i.up && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
        else if (step_i.dn && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign count_o = cnt_q;

    // R4: never wraps from the top to zero
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q == TOP) |=> cnt_q != '0);

    // R4: never wraps from zero to the top
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q == '0) |=> cnt_q != TOP);

    // R11: a load wins over any step
    a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == $past(load_val_i));

    // R1/R2: without a load the value moves by at most one
    a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)
                    || (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tri_level_counter.sv
module tri_level_counter
    import tlc_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int RESET_VAL    = 128,
    parameter int REJECT_TICKS = 20,
    parameter int ACCEPT_TICKS = 200,
    parameter int GAP_TICKS    = 10,
    parameter int START_TICKS  = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             line_lo_i,
    input  logic             line_hi_i,
    input  logic             ignore_next_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);
    level_t lvl_w;
    step_t  qual_w;
    step_t  step_w;

    tlc_level_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst(rst), .lo_i(line_lo_i), .hi_i(line_hi_i), .lvl_o(lvl_w)
    );

    tlc_pulse_qual #(.REJECT_TICKS(REJECT_TICKS), .ACCEPT_TICKS(ACCEPT_TICKS)) qual_i (
        .clk(clk), .rst(rst), .lvl_i(lvl_w), .qual_o(qual_w)
    );

    tlc_step_gate #(.GAP_TICKS(GAP_TICKS), .START_TICKS(START_TICKS)) gate_i (
        .clk(clk), .rst(rst), .en_i(en_i), .ignore_i(ignore_next_i),
        .qual_i(qual_w), .step_o(step_w)
    );

    tlc_sat_counter #(.CNT_W(CNT_W), .RESET_VAL(RESET_VAL)) cnt_i (
        .clk(clk), .rst(rst), .step_i(step_w), .load_i(load_i),
        .load_val_i(load_val_i), .count_o(count_o)
    );
endmodule

// File: tb/tri_level_counter_tb.sv
module tri_level_counter_tb_top;
    localparam int B_REJECT = 2;
    localparam int B_ACCEPT = 6;
    localparam int B_GAP    = 12;
    localparam int B_START  = 20;
    localparam int REST     = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       lo = 1'b0;
    logic       hi = 1'b0;
    logic       ign = 1'b0;
    logic       ld = 1'b0;
    logic [7:0] ld_val = '0;
    logic [7:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    int expv  = 128;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tri_level_counter #(
        .CNT_W(8), .RESET_VAL(128), .REJECT_TICKS(B_REJECT), .ACCEPT_TICKS(B_ACCEPT),
        .GAP_TICKS(B_GAP), .START_TICKS(B_START)
    ) dut_i (
        .clk(clk), .rst(rst), .en_i(en), .line_lo_i(lo), .line_hi_i(hi),
        .ignore_next_i(ign), .load_i(ld), .load_val_i(ld_val), .count_o(count)
    );

    task automatic check(input string tag, input int exp_val);
        n_cmp++;
        if (int'(count) != exp_val) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d", tag, count, exp_val);
        end
    endtask

    // dir 1: low side, 2: high side; held for w clock cycles, then rest
    task automatic swing(input int dir, input int w);
        @(negedge clk);
        lo = (dir == 1);
        hi = (dir == 2);
        repeat (w) @(negedge clk);
        lo = 1'b0;
        hi = 1'b0;
        repeat (REST) @(negedge clk);
    endtask

    function automatic int sat(input int v);
        if (v > 255) return 255;
        if (v < 0)   return 0;
        return v;
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset value", 128);

        // R7: disabled, a valid swing has no effect
        swing(1, 10);
        check("R7 disabled", 128);

        // R12/R8: first qualified swing after reset and enable is discarded
        en = 1'b1;
        repeat (B_START + 5) @(negedge clk);
        swing(1, 8);
        check("R12 first discarded", 128);
        swing(1, 8);
        expv = 129;
        check("R1 low swing up", expv);

        // R5/R1/R2: width sweep on both sides of the accept limit
        for (int w = 1; w <= 10; w++) begin
            swing(1, w);
            if (w >= B_ACCEPT) expv = sat(expv + 1);
            check($sformatf("R5 R1 low width %0d", w), expv);
        end
        for (int w = 1; w <= 10; w++) begin
            swing(2, w);
            if (w >= B_ACCEPT) expv = sat(expv - 1);
            check($sformatf("R5 R2 high width %0d", w), expv);
        end

        // R2: both comparator bits read as rest
        @(negedge clk);
        lo = 1'b1; hi = 1'b1;
        repeat (10) @(negedge clk);
        lo = 1'b0; hi = 1'b0;
        repeat (REST) @(negedge clk);
        check("R2 both bits rest", expv);

        // R3: no change while held, step after return
        @(negedge clk);
        lo = 1'b1;
        repeat (40) @(negedge clk);
        check("R3 held swing", expv);
        lo = 1'b0;
        repeat (REST) @(negedge clk);
        expv = sat(expv + 1);
        check("R3 after return", expv);

        // R6: second swing too soon after a step is dropped
        @(negedge clk);
        lo = 1'b1;
        repeat (B_ACCEPT) @(negedge clk);
        lo = 1'b0;
        @(negedge clk);
        lo = 1'b1;
        repeat (B_ACCEPT) @(negedge clk);
        lo = 1'b0;
        repeat (REST) @(negedge clk);
        expv = sat(expv + 1);
        check("R6 close pair", expv);
        swing(1, 8);
        expv = sat(expv + 1);
        check("R6 after gap", expv);

        // R10: direct low-to-high crossing is discarded
        @(negedge clk);
        lo = 1'b1;
        repeat (8) @(negedge clk);
        lo = 1'b0; hi = 1'b1;
        repeat (8) @(negedge clk);
        hi = 1'b0;
        repeat (REST) @(negedge clk);
        check("R10 crossing", expv);

        // R9: discard request
        @(negedge clk);
        ign = 1'b1;
        @(negedge clk);
        ign = 1'b0;
        swing(1, 8);
        check("R9 discarded", expv);
        swing(1, 8);
        expv = sat(expv + 1);
        check("R9 next counts", expv);

        // R8: re-enable, early swing dropped, then one discarded
        en = 1'b0;
        repeat (5) @(negedge clk);
        en = 1'b1;
        lo = 1'b1;
        repeat (B_ACCEPT + 1) @(negedge clk);
        lo = 1'b0;
        repeat (REST) @(negedge clk);
        check("R8 within start delay", expv);
        swing(1, 8);
        check("R8 first after delay", expv);
        swing(1, 8);
        expv = sat(expv + 1);
        check("R8 second after delay", expv);

        // R11/R4: load then saturate at the top
        @(negedge clk);
        ld = 1'b1; ld_val = 8'd254;
        @(negedge clk);
        ld = 1'b0;
        expv = 254;
        check("R11 load", expv);
        for (int k = 0; k < 3; k++) begin
            swing(1, 8);
            expv = sat(expv + 1);
            check("R4 top saturation", expv);
        end

        @(negedge clk);
        ld = 1'b1; ld_val = 8'd1;
        @(negedge clk);
        ld = 1'b0;
        expv = 1;
        check("R11 load low", expv);
        for (int k = 0; k < 3; k++) begin
            swing(2, 8);
            expv = sat(expv - 1);
            check("R4 bottom saturation", expv);
        end

        // R11: load held across a step wins
        @(negedge clk);
        lo = 1'b1;
        repeat (8) @(negedge clk);
        lo = 1'b0;
        ld = 1'b1; ld_val = 8'd77;
        repeat (12) @(negedge clk);
        ld = 1'b0;
        repeat (REST) @(negedge clk);
        expv = 77;
        check("R11 load priority", expv);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule